// File: doc/BRIEF.md
# Two-Wire Byte Memory Target with Upper-Quarter Write Lock

This block is the bus-side controller for a byte-wide synchronous memory of 2^ADDR_W locations, which is 8192 bytes at the default width. It acts as an I2C target. Its inputs are SCL and SDA lines that are already synchronised to the system clock and cleaned of glitches. It answers with a single open-drain pull-down enable. It detects bus Start and Stop conditions, checks the control byte against two board strap pins, and keeps one address pointer that persists between commands.

A write command loads the pointer from two address bytes and then stores any number of data bytes. A read command carries no address: it returns bytes from the current pointer for as long as the controller keeps acknowledging. A write-lock input protects the top quarter of the array. A busy input from the backup logic stops the block from answering, so that a bus controller can poll for completion.

The memory side is a plain request port without back-pressure. The memory must accept a request in every cycle in which `mem_req` is high. Read data must be valid on `mem_rdata` in the cycle after a read request. Each byte causes exactly one request, so requests stay dozens of system cycles apart.

Top module: `sram_i2c_target`

## Requirements
- R1: The block acknowledges a control byte only when bits 7..4 are 1010, bit 3 equals `strap_cs[1]`, bit 2 equals `strap_cs[0]` and bit 1 is 1. Bit 0 selects read (1) or write (0). For any other control byte it stays silent, for that byte and for every later byte, until the next Start.
- R2: While `busy` is high, no control byte is acknowledged. A rising edge of `busy` aborts any transfer in progress, and the block then ignores the bus until the next Start.
- R3: After a write control byte, two address bytes are each acknowledged and loaded into the pointer, high byte first. High-byte bits above ADDR_W-9 are ignored.
- R4: A write data byte is stored at the pointer at the SCL rising edge of its acknowledge bit, and the pointer then advances by one. A byte cut off by Stop or Start before that edge is not stored.
- R5: Consecutive data bytes in one write go to consecutive addresses, and the pointer wraps from the last location to 0.
- R6: A read starts at the current pointer. After any transfer the pointer holds the address that follows the last byte written or sent.
- R7: During a read, a controller ACK (SDA 0) makes the block send the next byte, wrapping past the last location to 0. A controller NACK (SDA 1) ends the read and leaves SDA released.
- R8: A repeated Start after the address bytes keeps the loaded pointer, so an address write followed by a read command gives a random read.
- R9: With `wprot` high, a data byte aimed at the top quarter of the array (both pointer MSBs 1) is not acknowledged and not stored, and the pointer does not advance. All bytes after it are ignored until the next Start. The control and address bytes are still acknowledged.
- R10: `wprot` has no effect on reads.
- R11: After reset the pointer is 0, SDA is released and no memory request is made.
- R12: The block changes SDA only while SCL is low. A new SDA level appears one system clock after the cycle in which the SCL falling edge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data (resolved line level) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_cs | input | 2 | Board strap bits compared with control-byte bits 3..2 |
| wprot | input | 1 | Write lock for the top quarter of the array |
| busy | input | 1 | Backup logic busy; blocks and aborts access |
| mem_req | output | 1 | Memory request strobe, one cycle per byte |
| mem_we | output | 1 | 1 for a write request, 0 for a read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |

## Verification
The bench builds the block with ADDR_W left at 13 and the strap pins tied to 10. The wrap point 0x1FFF and the locked range starting at 0x1800 are therefore reached by loading the pointer directly, not by long bursts. SCL half periods of four system clocks leave room for the one-cycle memory read and for the one-cycle SDA launch delay. The bench can therefore check the acknowledge bit at its exact launch cycle.

// File: rtl/sram_i2c_pkg.sv
package sram_i2c_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_AHI,
    PH_ALO,
    PH_WR,
    PH_RD
  } phase_e;

  localparam logic [3:0] CTRL_OPCODE = 4'b1010;
  localparam int         BYTE_W      = 8;
  localparam int         CNT_W       = 4;
  localparam logic [3:0] CNT_ACK     = 4'd8;
  localparam logic [3:0] CNT_POSTACK = 4'd9;
endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q;
  logic sda_q;

  // idle bus level is high on both lines
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign bus_start = scl_i & scl_q & sda_q & ~sda_i;
  assign bus_stop  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/sram_addr_ptr.sv
module sram_addr_ptr #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              inc,
  input  logic [7:0]        byte_in,
  output logic [ADDR_W-1:0] ptr,
  output logic              in_prot
);
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ld_hi) begin
      ptr_q[ADDR_W-1:8] <= byte_in[HI_W-1:0];
    end else if (ld_lo) begin
      ptr_q[7:0] <= byte_in;
    end else if (inc) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr     = ptr_q;
  assign in_prot = &ptr_q[ADDR_W-1 -: 2];

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_hi && !ld_lo && (&ptr_q)) |=> (ptr_q == '0)); // R5
endmodule

// File: rtl/i2c_sram_fsm.sv
module i2c_sram_fsm
  import sram_i2c_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              sda_i,
  input  logic [1:0]        strap_cs,
  input  logic              wprot,
  input  logic              busy,
  input  logic [ADDR_W-1:0] ptr,
  input  logic              in_prot,
  output logic              ld_hi,
  output logic              ld_lo,
  output logic              ptr_inc,
  output logic [7:0]        byte_rx,
  output logic              sda_oe,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  phase_e             phase;
  logic [CNT_W-1:0]   bitcnt;
  logic [BYTE_W-1:0]  shreg;
  logic [BYTE_W-1:0]  tx;
  logic               acked;
  logic               busy_q;
  logic               cap;
  logic               abort;
  logic               ctrl_ok;
  logic               wr_ok;
  logic               quiet;
  logic               commit;

  assign abort   = busy & ~busy_q;
  assign quiet   = abort | bus_stop | bus_start;
  assign ctrl_ok = (shreg[7:4] == CTRL_OPCODE) && (shreg[3:2] == strap_cs)
                   && shreg[1] && !busy;
  assign wr_ok   = !(wprot && in_prot);
  assign commit  = !quiet && scl_rise && (phase == PH_WR)
                   && (bitcnt == CNT_ACK) && acked;
  assign ld_hi   = !quiet && scl_fall && (phase == PH_AHI) && (bitcnt == CNT_ACK);
  assign ld_lo   = !quiet && scl_fall && (phase == PH_ALO) && (bitcnt == CNT_ACK);
  assign ptr_inc = commit | cap;
  assign byte_rx = shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      tx        <= '0;
      acked     <= 1'b0;
      busy_q    <= 1'b0;
      cap       <= 1'b0;
      sda_oe    <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      busy_q  <= busy;
      mem_req <= 1'b0;
      cap     <= mem_req & ~mem_we;
      if (cap) tx <= mem_rdata;

      if (abort || bus_stop) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else if (bus_start) begin
        phase  <= PH_CTRL;
        bitcnt <= '0;
        acked  <= 1'b0;
        sda_oe <= 1'b0;
      end else if (phase == PH_IDLE) begin
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        if (bitcnt < CNT_ACK) begin
          shreg  <= {shreg[6:0], sda_i};
          bitcnt <= bitcnt + 1'b1;
        end else if (bitcnt == CNT_ACK) begin
          bitcnt <= CNT_POSTACK;
          unique case (phase)
            PH_CTRL: begin
              if (shreg[0]) begin
                phase    <= PH_RD;
                mem_req  <= 1'b1;
                mem_we   <= 1'b0;
                mem_addr <= ptr;
              end else begin
                phase <= PH_AHI;
              end
            end
            PH_AHI: phase <= PH_ALO;
            PH_ALO: phase <= PH_WR;
            PH_WR: begin
              if (acked) begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= ptr;
                mem_wdata <= shreg;
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_RD: begin
              if (!sda_i) begin
                mem_req  <= 1'b1;
                mem_we   <= 1'b0;
                mem_addr <= ptr;
              end else begin
                phase <= PH_IDLE;
              end
            end
            default: phase <= PH_IDLE;
          endcase
        end
      end else if (scl_fall) begin
        if (bitcnt == CNT_ACK) begin
          unique case (phase)
            PH_CTRL: begin
              if (ctrl_ok) begin
                acked  <= 1'b1;
                sda_oe <= 1'b1;
              end else begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
              end
            end
            PH_AHI, PH_ALO: begin
              acked  <= 1'b1;
              sda_oe <= 1'b1;
            end
            PH_WR: begin
              acked  <= wr_ok;
              sda_oe <= wr_ok;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (bitcnt == CNT_POSTACK) begin
          bitcnt <= '0;
          sda_oe <= (phase == PH_RD) ? ~tx[7] : 1'b0;
        end else if (phase == PH_RD && bitcnt != '0) begin
          sda_oe <= ~tx[3'd7 - bitcnt[2:0]];
        end
      end
    end
  end

  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CTRL && scl_fall && bitcnt == CNT_ACK && busy) |=> !sda_oe); // R2
  AST_BUSY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> (phase == PH_IDLE && !sda_oe)); // R2
  AST_NACK_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RD && scl_rise && bitcnt == CNT_ACK && sda_i && !abort)
      |=> (phase == PH_IDLE)); // R7
  AST_ADDR_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi || ld_lo) |=> sda_oe); // R3
endmodule

// File: rtl/sram_i2c_target.sv
module sram_i2c_target #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        strap_cs,
  input  logic              wprot,
  input  logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  logic              scl_rise;
  logic              scl_fall;
  logic              bus_start;
  logic              bus_stop;
  logic              ld_hi;
  logic              ld_lo;
  logic              ptr_inc;
  logic              in_prot;
  logic [7:0]        byte_rx;
  logic [ADDR_W-1:0] ptr;

  i2c_line_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  sram_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_hi   (ld_hi),
    .ld_lo   (ld_lo),
    .inc     (ptr_inc),
    .byte_in (byte_rx),
    .ptr     (ptr),
    .in_prot (in_prot)
  );

  i2c_sram_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .sda_i     (sda_i),
    .strap_cs  (strap_cs),
    .wprot     (wprot),
    .busy      (busy),
    .ptr       (ptr),
    .in_prot   (in_prot),
    .ld_hi     (ld_hi),
    .ld_lo     (ld_lo),
    .ptr_inc   (ptr_inc),
    .byte_rx   (byte_rx),
    .sda_oe    (sda_oe),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i); // R12
  AST_WR_NOT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !($past(wprot) && (&mem_addr[ADDR_W-1 -: 2]))); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!mem_req && !sda_oe)); // R11
endmodule

// File: tb/test_sram_i2c_target.sv
`timescale 1ns/100ps
module test_sram_i2c_target;
  localparam int AW = 13;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wprot = 1'b0;
  logic busy = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;
  logic [7:0] dev_mem [DEPTH];
  logic [7:0] exp_mem [DEPTH];

  int checks = 0;
  int errors = 0;
  bit oe_before, oe_after;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  sram_i2c_target #(.ADDR_W(AW)) i_sram_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_cs(2'b10), .wprot(wprot), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: fills itself during reset, answers one cycle after a read request
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) dev_mem[i] <= 8'(i * 13 + 5);
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) dev_mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= dev_mem[mem_addr];
    end
  end

  // addr, data, wprot, expected data ack
  localparam logic [22:0] VEC [8] = '{
    {13'h0000, 8'hA5, 1'b0, 1'b1},
    {13'h0123, 8'h3C, 1'b0, 1'b1},
    {13'h17FF, 8'h81, 1'b1, 1'b1},
    {13'h1800, 8'h7E, 1'b1, 1'b0},
    {13'h1FFF, 8'h55, 1'b1, 1'b0},
    {13'h1FFF, 8'h66, 1'b0, 1'b1},
    {13'h1800, 8'h99, 1'b0, 1'b1},
    {13'h0ABC, 8'h00, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; cyc(4);
    scl_m = 1'b1; cyc(4);
    sda_m = 1'b0; cyc(4);
    scl_m = 1'b0; cyc(4);
  endtask

  task automatic bstop();
    sda_m = 1'b0; cyc(4);
    scl_m = 1'b1; cyc(4);
    sda_m = 1'b1; cyc(4);
  endtask

  task automatic tx_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; cyc(4);
      scl_m = 1'b1; cyc(4);
      scl_m = 1'b0;
    end
    sda_m = 1'b1;
    oe_before = sda_oe;
    cyc(1);
    oe_after = sda_oe;
    cyc(3);
    scl_m = 1'b1; cyc(2);
    ack = !sda_line;
    cyc(2);
    scl_m = 1'b0;
  endtask

  task automatic rx_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      cyc(4);
      scl_m = 1'b1; cyc(2);
      b[i] = sda_line;
      cyc(2);
      scl_m = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1;
    cyc(4);
    scl_m = 1'b1; cyc(4);
    scl_m = 1'b0; cyc(1);
    sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [12:0] a, output bit ok);
    bit k0, k1, k2;
    bstart();
    tx_byte(8'hAA, k0);
    tx_byte({3'b000, a[12:8]}, k1);
    tx_byte(a[7:0], k2);
    ok = k0 & k1 & k2;
  endtask

  task automatic cur_read(output logic [7:0] b, output bit ok);
    bstart();
    tx_byte(8'hAB, ok);
    rx_byte(1'b0, b);
    bstop();
  endtask

  task automatic rand_read(input logic [12:0] a, output logic [7:0] b);
    bit ok;
    set_ptr(a, ok);
    cur_read(b, ok);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ak, ok;
    logic [7:0] rb;
    logic [12:0] va;
    logic [7:0] vd;
    bit vw, ve;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'(i * 13 + 5);

    cyc(5);
    check(!sda_oe && !mem_req, "R11 reset outputs", {sda_oe, mem_req}, 0);
    rst_n = 1'b1;
    cyc(3);

    // R11: pointer starts at 0
    cur_read(rb, ok);
    check(ok && rb == exp_mem[0], "R11 first read at 0", rb, exp_mem[0]);

    // R1: bad control bytes get no ACK, nor do later bytes
    bstart();
    tx_byte(8'hA6, ak);
    check(!ak, "R1 strap mismatch", ak, 0);
    tx_byte(8'h00, ak);
    check(!ak, "R1 silent until Start", ak, 0);
    bstart();
    tx_byte(8'hA8, ak);
    check(!ak, "R1 fixed bit zero", ak, 0);
    bstart();
    tx_byte(8'hBA, ak);
    check(!ak, "R1 wrong opcode", ak, 0);
    bstart();
    tx_byte(8'hAA, ak);
    check(ak, "R1 matching control byte", ak, 1);
    // R12: ack launched one clock after the SCL fall is seen
    check(!oe_before && oe_after, "R12 ack launch timing", {oe_before, oe_after}, 1);
    bstop();

    // table walk: write one byte, then random read it back
    for (int k = 0; k < 8; k++) begin
      {va, vd, vw, ve} = VEC[k];
      wprot = vw;
      set_ptr(va, ok);
      tx_byte(vd, ak);
      bstop();
      check(ok, "R3 address acked", ok, 1);
      if (ve) check(ak, "R4 data ack", ak, 1);
      else    check(!ak, "R9 locked data nack", ak, 0);
      if (ve) exp_mem[va] = vd;
      rand_read(va, rb);
      if (vw) check(rb == exp_mem[va], "R10 read with lock", rb, exp_mem[va]);
      else    check(rb == exp_mem[va], "R8 random read", rb, exp_mem[va]);
    end
    wprot = 1'b0;

    // R3: high-byte top bits ignored
    bstart();
    tx_byte(8'hAA, ak);
    tx_byte(8'hE1, ak);
    tx_byte(8'h23, ak);
    tx_byte(8'h4D, ak);
    bstop();
    exp_mem[13'h0123] = 8'h4D;
    rand_read(13'h0123, rb);
    check(rb == 8'h4D, "R3 top bits ignored", rb, 8'h4D);

    // R5: sequential write across the wrap
    set_ptr(13'h1FFE, ok);
    tx_byte(8'h11, ak);
    tx_byte(8'h22, ak);
    tx_byte(8'h33, ak);
    bstop();
    exp_mem[13'h1FFE] = 8'h11;
    exp_mem[13'h1FFF] = 8'h22;
    exp_mem[13'h0000] = 8'h33;
    check(dev_mem[13'h1FFE] == 8'h11 && dev_mem[13'h1FFF] == 8'h22 && dev_mem[0] == 8'h33,
          "R5 wrap write", dev_mem[0], 8'h33);
    // R6: pointer follows the last byte written
    cur_read(rb, ok);
    check(rb == exp_mem[1], "R6 pointer after write", rb, exp_mem[1]);

    // R7 and R10: sequential read across the wrap with the lock set
    wprot = 1'b1;
    set_ptr(13'h1FFF, ok);
    bstart();
    tx_byte(8'hAB, ak);
    rx_byte(1'b1, rb);
    check(rb == exp_mem[13'h1FFF], "R10 locked-range read", rb, exp_mem[13'h1FFF]);
    rx_byte(1'b0, rb);
    check(rb == exp_mem[0], "R7 read wrap", rb, exp_mem[0]);
    cyc(4);
    check(!sda_oe, "R7 released after NACK", sda_oe, 0);
    bstop();
    cur_read(rb, ok);
    check(rb == exp_mem[1], "R6 pointer after read", rb, exp_mem[1]);

    // R9: locked write ends the transfer and keeps the pointer
    set_ptr(13'h1900, ok);
    check(ok, "R9 address still acked", ok, 1);
    tx_byte(8'hC3, ak);
    check(!ak, "R9 data nack", ak, 0);
    wprot = 1'b0;
    tx_byte(8'hC4, ak);
    check(!ak, "R9 ignored until Start", ak, 0);
    bstop();
    check(dev_mem[13'h1900] == exp_mem[13'h1900] && dev_mem[13'h1901] == exp_mem[13'h1901],
          "R9 memory unchanged", dev_mem[13'h1900], exp_mem[13'h1900]);
    cur_read(rb, ok);
    check(rb == exp_mem[13'h1900], "R9 pointer not advanced", rb, exp_mem[13'h1900]);

    // R2: busy blocks the control byte and aborts a transfer
    busy = 1'b1;
    cyc(3);
    bstart();
    tx_byte(8'hAA, ak);
    check(!ak, "R2 no ack while busy", ak, 0);
    bstop();
    busy = 1'b0;
    cyc(3);
    set_ptr(13'h0200, ok);
    check(ok, "R2 ack after busy clears", ok, 1);
    busy = 1'b1;
    cyc(3);
    busy = 1'b0;
    cyc(2);
    tx_byte(8'h77, ak);
    check(!ak, "R2 aborted transfer ignored", ak, 0);
    bstop();
    rand_read(13'h0200, rb);
    check(rb == exp_mem[13'h0200], "R2 aborted byte not stored", rb, exp_mem[13'h0200]);

    // R4: a byte cut off before its ACK edge is lost, the earlier one is kept
    set_ptr(13'h0300, ok);
    tx_byte(8'h5E, ak);
    for (int i = 0; i < 4; i++) begin
      sda_m = i[0]; cyc(4);
      scl_m = 1'b1; cyc(4);
      scl_m = 1'b0;
    end
    bstop();
    exp_mem[13'h0300] = 8'h5E;
    rand_read(13'h0300, rb);
    check(rb == 8'h5E, "R4 completed byte stored", rb, 8'h5E);
    rand_read(13'h0301, rb);
    check(rb == exp_mem[13'h0301], "R4 partial byte dropped", rb, exp_mem[13'h0301]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule